// File: doc/BRIEF.md
# Paired-Register I2C Target with Sticky Read Pointer

This block is the serial front end of a 16-bit port expander. It watches an I2C bus through synchronised SCL and SDA samples. It answers its own 7-bit address, takes a command byte that selects one register, and then either stores written bytes or returns register bytes. The target pulls SDA low through an open-drain enable and never drives SCL.

The registers come in pairs, each pair holding the low byte and the high byte of one 16-bit quantity. The pairs are the input pins, the output latch, the polarity inversion mask and the direction configuration. Each byte that is read or written moves the pointer to the other member of its pair, so a long transfer alternates between the two bytes. The pointer always names the register being moved at that moment. After a repeated start, a read therefore continues from wherever the previous read stopped, and the command byte sent originally is lost.

A controller uses the block in one of two ways. It can write the address, send a command byte, issue a repeated start and then read. If the pointer already holds the wanted register, it can address the target for reading straight away.

Top module: `i2c_pair_regs`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal `{TGT_ADDR[6:1], addr_sel}`. For any other address it leaves SDA released, including in the acknowledge slot, and ignores all bits until the next START.
- R2: In a write, the byte after the address is the command, and every later byte is stored in the register the pointer names. Index 2/3 is the output latch, 4/5 the polarity mask and 6/7 the configuration. An even index holds bits 7:0 of its port and an odd index holds bits 15:8.
- R3: After each stored byte the pointer flips bit 0, so the next byte of the same write lands in the other member of the pair.
- R4: A read returns the byte the pointer names, with the most significant bit first. Index 0 returns `port_in[7:0] ^ port_pol[7:0]` and index 1 returns `port_in[15:8] ^ port_pol[15:8]`.
- R5: When the controller acknowledges a read byte, the pointer flips bit 0 and the next byte comes from the pair partner. The bytes keep alternating for as long as the read continues.
- R6: The pointer always holds the register whose byte was last loaded for sending. A read after a repeated start begins at that register, not at the command value written earlier.
- R7: Input pins are captured into the transmit shift register at the SCL rising edge of the acknowledge slot that comes before the byte. A change on `port_in` after that edge does not alter the byte being sent.
- R8: A not-acknowledge from the controller ends the read. The target releases SDA and does not drive it again until it has been addressed anew.
- R9: A STOP at any bit position returns the target to idle with SDA released. A byte that was only partly shifted in is discarded and the registers keep their values.
- R10: Command values of 8 and above read as 0x00. Writes to them, and writes to index 0 or 1, leave every register unchanged.
- R11: A read that is addressed directly, with no command byte, starts at the current pointer. After reset the pointer is 0.
- R12: After reset `sda_oe` is 0, `port_out` equals `OUT_RST` (0xFFFF), `port_pol` equals `POL_RST` (0x0000) and `port_cfg` equals `CFG_RST` (0xFFFF).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled serial clock line |
| sda_i | input | 1 | Sampled serial data line |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| addr_sel | input | 1 | Strap that supplies the address LSB |
| port_in | input | 16 | Parallel input pins |
| port_out | output | 16 | Output latch register |
| port_pol | output | 16 | Polarity inversion mask |
| port_cfg | output | 16 | Direction configuration register |

## Verification
One SCL rising edge in the acknowledge slot does two jobs at once. It samples the controller's ACK, which flips the pointer, and it captures the input pins into the shift register. The bench provokes this by changing `port_in` in the middle of the high phase of that slot. A correct design returns the pre-change value, while the byte after the next acknowledge reflects the new pins. A second overlap arises when a repeated start falls on a transfer whose pointer has moved during the read. The bench judges it by the first byte after the restart, which must come from the register that was last loaded and not from the command byte.

// File: rtl/i2cpr_pkg.sv
package i2cpr_pkg;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned PORT_W = 2 * BYTE_W;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_CMD,
      ST_CMD_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RDATA_ACK
   } bus_state_t;

   // partner register inside a pair differs only in bit 0
   function automatic logic [BYTE_W-1:0] pair_mate(input logic [BYTE_W-1:0] idx);
      return {idx[BYTE_W-1:1], ~idx[0]};
   endfunction

endpackage

// File: rtl/i2cpr_sync.sv
module i2cpr_sync #(
   parameter int unsigned STAGES   = 2,
   parameter logic        IDLE_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic lvl_o,
   output logic rise_o,
   output logic fall_o
);

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2cpr_sync: STAGES must be 2 or more");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{IDLE_LVL}};
         prev_q  <= IDLE_LVL;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign lvl_o  = chain_q[STAGES-1];
   assign rise_o = lvl_o & ~prev_q;
   assign fall_o = ~lvl_o & prev_q;

endmodule

// File: rtl/i2cpr_bank.sv
module i2cpr_bank
   import i2cpr_pkg::*;
#(
   parameter logic [PORT_W-1:0] OUT_RST = 16'hFFFF,
   parameter logic [PORT_W-1:0] POL_RST = 16'h0000,
   parameter logic [PORT_W-1:0] CFG_RST = 16'hFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_idx,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [BYTE_W-1:0] rd_idx,
   output logic [BYTE_W-1:0] rd_data,
   input  logic [PORT_W-1:0] port_in,
   output logic [PORT_W-1:0] port_out,
   output logic [PORT_W-1:0] port_pol,
   output logic [PORT_W-1:0] port_cfg
);

   localparam int unsigned GRP_CNT  = 4;
   localparam int unsigned REG_CNT  = 2 * GRP_CNT;
   localparam int unsigned FIRST_RW = 2;
   localparam int unsigned OUT_BASE = 2;
   localparam int unsigned POL_BASE = 4;
   localparam int unsigned CFG_BASE = 6;
   localparam logic [REG_CNT*BYTE_W-1:0] RST_VEC =
      {CFG_RST, POL_RST, OUT_RST, {PORT_W{1'b0}}};

   logic [BYTE_W-1:0] store_q [FIRST_RW:REG_CNT-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = FIRST_RW; k < REG_CNT; k++)
            store_q[k] <= RST_VEC[k*BYTE_W +: BYTE_W];
      end else begin
         for (int k = FIRST_RW; k < REG_CNT; k++)
            if (wr_en && wr_idx == BYTE_W'(k))
               store_q[k] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_idx < BYTE_W'(FIRST_RW)) begin
         if (rd_idx[0]) rd_data = port_in[PORT_W-1:BYTE_W] ^ store_q[POL_BASE+1];
         else           rd_data = port_in[BYTE_W-1:0]      ^ store_q[POL_BASE];
      end else if (rd_idx < BYTE_W'(REG_CNT)) begin
         rd_data = store_q[rd_idx[$clog2(REG_CNT)-1:0]];
      end
   end

   assign port_out = {store_q[OUT_BASE+1], store_q[OUT_BASE]};
   assign port_pol = {store_q[POL_BASE+1], store_q[POL_BASE]};
   assign port_cfg = {store_q[CFG_BASE+1], store_q[CFG_BASE]};

   // R10: writes outside the writable window change nothing
   p_no_stray_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_idx < BYTE_W'(FIRST_RW) || wr_idx >= BYTE_W'(REG_CNT)))
      |=> $stable({port_out, port_pol, port_cfg}));

   // R2: an accepted write shows up on the port outputs one cycle later
   p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == BYTE_W'(OUT_BASE)) |=> port_out[BYTE_W-1:0] == $past(wr_data));

endmodule

// File: rtl/i2c_pair_regs.sv
module i2c_pair_regs
   import i2cpr_pkg::*;
#(
   parameter logic [BYTE_W-2:0] TGT_ADDR    = 7'h22,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter logic [PORT_W-1:0] OUT_RST     = 16'hFFFF,
   parameter logic [PORT_W-1:0] POL_RST     = 16'h0000,
   parameter logic [PORT_W-1:0] CFG_RST     = 16'hFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic              addr_sel,
   input  logic [PORT_W-1:0] port_in,
   output logic [PORT_W-1:0] port_out,
   output logic [PORT_W-1:0] port_pol,
   output logic [PORT_W-1:0] port_cfg
);

   localparam int unsigned       CNT_W    = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(BYTE_W - 1);

   logic scl_lvl, scl_rise, scl_fall;
   logic sda_lvl, sda_rise, sda_fall;
   logic start_det, stop_det;

   i2cpr_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(scl_i),
      .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

   i2cpr_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(sda_i),
      .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

   assign start_det = scl_lvl & sda_fall;
   assign stop_det  = scl_lvl & sda_rise;

   bus_state_t        state_q;
   logic [CNT_W-1:0]  bit_q;
   logic              byte_done_q;
   logic              rw_q;
   logic              ack_ok_q;
   logic              oe_q;
   logic [BYTE_W-1:0] sh_q;
   logic [BYTE_W-1:0] cmd_q;
   logic [BYTE_W-1:0] rd_idx;
   logic [BYTE_W-1:0] rd_data;
   logic [BYTE_W-2:0] own_addr;
   logic              wr_en;

   assign own_addr = {TGT_ADDR[BYTE_W-2:1], addr_sel};
   assign rd_idx   = (state_q == ST_RDATA_ACK) ? pair_mate(cmd_q) : cmd_q;
   assign wr_en    = (state_q == ST_WDATA) && scl_fall && byte_done_q;
   assign sda_oe   = oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         bit_q       <= '0;
         byte_done_q <= 1'b0;
         rw_q        <= 1'b0;
         ack_ok_q    <= 1'b0;
         oe_q        <= 1'b0;
         sh_q        <= '0;
         cmd_q       <= '0;
      end else if (start_det) begin
         state_q     <= ST_ADDR;
         bit_q       <= '0;
         byte_done_q <= 1'b0;
         oe_q        <= 1'b0;
      end else if (stop_det) begin
         state_q     <= ST_IDLE;
         byte_done_q <= 1'b0;
         oe_q        <= 1'b0;
      end else if (scl_rise) begin
         case (state_q)
            ST_ADDR, ST_CMD, ST_WDATA: begin
               sh_q        <= {sh_q[BYTE_W-2:0], sda_lvl};
               bit_q       <= bit_q + 1'b1;
               byte_done_q <= (bit_q == LAST_BIT);
            end
            ST_ADDR_ACK: if (rw_q) sh_q <= rd_data;
            ST_RDATA: begin
               bit_q       <= bit_q + 1'b1;
               byte_done_q <= (bit_q == LAST_BIT);
            end
            ST_RDATA_ACK: begin
               ack_ok_q <= ~sda_lvl;
               if (!sda_lvl) begin
                  cmd_q <= pair_mate(cmd_q);
                  sh_q  <= rd_data;
               end
            end
            default: ;
         endcase
      end else if (scl_fall) begin
         case (state_q)
            ST_ADDR: if (byte_done_q) begin
               byte_done_q <= 1'b0;
               if (sh_q[BYTE_W-1:1] == own_addr) begin
                  rw_q    <= sh_q[0];
                  state_q <= ST_ADDR_ACK;
                  oe_q    <= 1'b1;
               end else begin
                  state_q <= ST_IDLE;
               end
            end
            ST_ADDR_ACK: begin
               bit_q <= '0;
               if (rw_q) begin
                  state_q <= ST_RDATA;
                  oe_q    <= ~sh_q[BYTE_W-1];
               end else begin
                  state_q <= ST_CMD;
                  oe_q    <= 1'b0;
               end
            end
            ST_CMD: if (byte_done_q) begin
               byte_done_q <= 1'b0;
               cmd_q       <= sh_q;
               state_q     <= ST_CMD_ACK;
               oe_q        <= 1'b1;
            end
            ST_CMD_ACK, ST_WDATA_ACK: begin
               oe_q    <= 1'b0;
               state_q <= ST_WDATA;
            end
            ST_WDATA: if (byte_done_q) begin
               byte_done_q <= 1'b0;
               cmd_q       <= pair_mate(cmd_q);
               state_q     <= ST_WDATA_ACK;
               oe_q        <= 1'b1;
            end
            ST_RDATA: begin
               if (byte_done_q) begin
                  byte_done_q <= 1'b0;
                  oe_q        <= 1'b0;
                  state_q     <= ST_RDATA_ACK;
               end else begin
                  sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
                  oe_q <= ~sh_q[BYTE_W-2];
               end
            end
            ST_RDATA_ACK: begin
               if (ack_ok_q) begin
                  state_q <= ST_RDATA;
                  bit_q   <= '0;
                  oe_q    <= ~sh_q[BYTE_W-1];
               end else begin
                  state_q <= ST_IDLE;
                  oe_q    <= 1'b0;
               end
            end
            default: ;
         endcase
      end
   end

   i2cpr_bank #(.OUT_RST(OUT_RST), .POL_RST(POL_RST), .CFG_RST(CFG_RST)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(cmd_q), .wr_data(sh_q),
      .rd_idx(rd_idx), .rd_data(rd_data),
      .port_in(port_in), .port_out(port_out), .port_pol(port_pol), .port_cfg(port_cfg));

   // R1: a foreign address never earns an acknowledge
   p_foreign_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ADDR && scl_fall && byte_done_q && sh_q[BYTE_W-1:1] != own_addr)
      |=> (!sda_oe && state_q == ST_IDLE));

   // R9: SDA is only ever pulled low while SCL is low
   p_pull_in_low_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_lvl);

   // R9: STOP releases the bus and returns to idle
   p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (!sda_oe && state_q == ST_IDLE));

   // R5: a controller ACK moves the pointer to the pair partner
   p_read_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RDATA_ACK && scl_rise && !sda_lvl && !start_det && !stop_det)
      |=> cmd_q == pair_mate($past(cmd_q)));

   // R3: each stored byte moves the pointer to the pair partner
   p_write_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> cmd_q == pair_mate($past(cmd_q)));

   // R8: a NACK ends the read with SDA released
   p_nack_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RDATA_ACK && scl_fall && !ack_ok_q)
      |=> (state_q == ST_IDLE && !sda_oe));

endmodule

// File: tb/i2c_pair_regs_test.sv
module i2c_pair_regs_test;

   localparam int HALF = 10;
   localparam int QTR  = HALF / 2;
   localparam logic [7:0] WR_ADDR  = 8'h46;
   localparam logic [7:0] RD_ADDR  = 8'h47;
   localparam logic [7:0] BAD_ADDR = 8'h44;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic        sda_oe;
   logic        sda_line;
   logic        addr_sel = 1'b1;
   logic [15:0] port_in = 16'h0000;
   logic [15:0] port_out, port_pol, port_cfg;

   always #5 clk = ~clk;
   assign sda_line = sda_m & ~sda_oe;

   i2c_pair_regs uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
      .addr_sel(addr_sel), .port_in(port_in),
      .port_out(port_out), .port_pol(port_pol), .port_cfg(port_cfg));

   int checks = 0;
   int errors = 0;
   string      tag_q[$];
   logic [7:0] val_q[$];
   logic [7:0] mon_byte;
   event       byte_ev;
   logic        hook_en = 1'b0;
   logic [15:0] hook_val = 16'h0000;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic expect_byte(input string tag, input logic [7:0] v);
      tag_q.push_back(tag);
      val_q.push_back(v);
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(byte_ev);
         if (val_q.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL unexpected read byte: actual %0h expected none", mon_byte);
         end else begin
            string      t;
            logic [7:0] e;
            t = tag_q.pop_front();
            e = val_q.pop_front();
            check(t, {24'h0, mon_byte}, {24'h0, e});
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   task automatic wq(); repeat (QTR) @(negedge clk); endtask
   task automatic wh(); repeat (HALF) @(negedge clk); endtask

   task automatic i2c_start();
      wq(); sda_m = 1'b1; wq(); scl_m = 1'b1; wh(); sda_m = 1'b0; wh(); scl_m = 1'b0;
   endtask

   task automatic i2c_stop();
      wq(); sda_m = 1'b0; wq(); scl_m = 1'b1; wh(); sda_m = 1'b1; wh();
   endtask

   task automatic bit_out(input logic b);
      wq(); sda_m = b; wq(); scl_m = 1'b1; wh(); scl_m = 1'b0;
   endtask

   task automatic bit_in(output logic b);
      wq(); sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] d, output logic ackd);
      logic a;
      for (int i = 7; i >= 0; i--) bit_out(d[i]);
      wq(); sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
      a = sda_line;
      if (hook_en) begin
         port_in = hook_val;
         hook_en = 1'b0;
      end
      wq(); scl_m = 1'b0;
      ackd = ~a;
   endtask

   task automatic recv_byte(input logic ack);
      logic [7:0] d;
      for (int i = 7; i >= 0; i--) begin
         logic b;
         bit_in(b);
         d[i] = b;
      end
      mon_byte = d;
      -> byte_ev;
      bit_out(~ack);
   endtask

   // address for write and send a command byte, acks checked against R1
   task automatic send_cmd(input logic [7:0] c);
      logic a;
      i2c_start();
      send_byte(WR_ADDR, a);
      check("R1 own address acknowledged", {31'h0, a}, 32'h1);
      send_byte(c, a);
   endtask

   initial begin
      logic a;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R12 reset state
      check("R12 sda_oe after reset", {31'h0, sda_oe}, 32'h0);
      check("R12 port_out after reset", {16'h0, port_out}, 32'hFFFF);
      check("R12 port_pol after reset", {16'h0, port_pol}, 32'h0000);
      check("R12 port_cfg after reset", {16'h0, port_cfg}, 32'hFFFF);

      // R1 foreign address, then data bits that must be ignored
      i2c_start();
      send_byte(BAD_ADDR, a);
      check("R1 foreign address not acked", {31'h0, a}, 32'h0);
      send_byte(8'h02, a);
      check("R1 bytes after foreign address not acked", {31'h0, a}, 32'h0);
      send_byte(8'h00, a);
      i2c_stop();
      check("R1 foreign transfer leaves port_out", {16'h0, port_out}, 32'hFFFF);

      // R2 R3 output latch, two bytes toggle 2 -> 3
      send_cmd(8'h02);
      send_byte(8'hA5, a);
      send_byte(8'h3C, a);
      i2c_stop();
      check("R2 R3 output latch written as pair", {16'h0, port_out}, 32'h3CA5);

      // R3 configuration starting on odd member: 7 -> 6
      send_cmd(8'h07);
      send_byte(8'h22, a);
      send_byte(8'h11, a);
      i2c_stop();
      check("R3 config written odd then even", {16'h0, port_cfg}, 32'h2211);

      // R2 polarity mask
      send_cmd(8'h04);
      send_byte(8'h0F, a);
      send_byte(8'hF0, a);
      i2c_stop();
      check("R2 polarity mask written", {16'h0, port_pol}, 32'hF00F);

      // R4 R5 R8 read input pair starting at index 1
      port_in = 16'h5AC3;
      send_cmd(8'h01);
      i2c_start();
      send_byte(RD_ADDR, a);
      expect_byte("R4 input high byte with inversion", 8'hAA);
      recv_byte(1'b1);
      expect_byte("R5 partner input byte", 8'hCC);
      recv_byte(1'b1);
      expect_byte("R5 alternation back to index 1", 8'hAA);
      recv_byte(1'b0);
      wq();
      check("R8 SDA released after NACK", {31'h0, sda_oe}, 32'h0);
      bit_in(a);
      check("R8 target silent after NACK", {31'h0, a}, 32'h1);
      check("R8 no drive during extra clock", {31'h0, sda_oe}, 32'h0);
      i2c_stop();

      // R6 pointer follows the read, restart resumes there
      send_cmd(8'h02);
      i2c_start();
      send_byte(RD_ADDR, a);
      expect_byte("R4 output low byte", 8'hA5);
      recv_byte(1'b1);
      expect_byte("R5 output high byte", 8'h3C);
      recv_byte(1'b0);
      i2c_start();
      send_byte(RD_ADDR, a);
      expect_byte("R6 restart resumes at index 3", 8'h3C);
      recv_byte(1'b1);
      expect_byte("R6 then partner index 2", 8'hA5);
      recv_byte(1'b0);
      i2c_stop();

      // R11 direct read at pointer 0, R7 pin change after ACK-slot edge
      send_cmd(8'h00);
      i2c_stop();
      port_in  = 16'h1234;
      hook_val = 16'hFFFF;
      hook_en  = 1'b1;
      i2c_start();
      send_byte(RD_ADDR, a);
      check("R11 direct read addressed", {31'h0, a}, 32'h1);
      expect_byte("R7 R11 byte captured before pin change", 8'h3B);
      recv_byte(1'b1);
      expect_byte("R7 next byte sees new pins", 8'h0F);
      recv_byte(1'b0);
      i2c_stop();

      // R10 unused command: writes ignored, reads zero
      send_cmd(8'h09);
      send_byte(8'h77, a);
      send_byte(8'h66, a);
      i2c_stop();
      check("R10 port_out untouched", {16'h0, port_out}, 32'h3CA5);
      check("R10 port_pol untouched", {16'h0, port_pol}, 32'hF00F);
      check("R10 port_cfg untouched", {16'h0, port_cfg}, 32'h2211);
      send_cmd(8'h01);
      send_byte(8'h99, a);
      i2c_stop();
      check("R10 input register write ignored", {16'h0, port_out ^ port_pol ^ port_cfg},
            {16'h0, 16'h3CA5 ^ 16'hF00F ^ 16'h2211});
      send_cmd(8'h09);
      i2c_start();
      send_byte(RD_ADDR, a);
      expect_byte("R10 unused index 9 reads zero", 8'h00);
      recv_byte(1'b1);
      expect_byte("R10 unused index 8 reads zero", 8'h00);
      recv_byte(1'b0);
      i2c_stop();

      // R9 STOP in the middle of a data byte
      send_cmd(8'h02);
      for (int i = 0; i < 4; i++) bit_out(1'b0);
      i2c_stop();
      repeat (4) @(negedge clk);
      check("R9 SDA released after STOP", {31'h0, sda_oe}, 32'h0);
      check("R9 partial byte discarded", {16'h0, port_out}, 32'h3CA5);
      send_cmd(8'h03);
      i2c_start();
      send_byte(RD_ADDR, a);
      expect_byte("R9 bus usable after aborted write", 8'h3C);
      recv_byte(1'b0);
      i2c_stop();

      repeat (20) @(negedge clk);
      check("scoreboard drained", val_q.size(), 0);
      finish_run();
   end

endmodule